// File: doc/BRIEF.md
# Three-Bin Service Trolley Scheduler

This controller decides, once per clock period, which of three material bins a delivery trolley serves. Each bin has a level sensor that reads 1 when the bin runs low and needs material. The controller answers with a one-hot selection of the bin to serve during the coming period, or with no selection when nothing is asked for. Every decision lasts exactly one period, whatever the bin's distance.

Competing requests are shared by history, not by a fixed ranking. The controller remembers which bin it served last, in one of four states: `ST_IDLE` (nothing served, or history cleared), and `ST_LAST1`, `ST_LAST2` and `ST_LAST3` (bin 1, 2 or 3 served last). From any state the next grant goes to the first requesting bin found by walking forward in the cyclic order 1, 2, 3, starting just after the bin served last.

`ST_IDLE` behaves as if bin 3 had been served last, so the search starts at bin 1. There are two kinds of transition. A grant moves the machine to the `ST_LASTn` state of the bin it picked. An empty request vector moves it to `ST_IDLE`.

Top module: `trolley_sched`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears `serve_sel` to 3'b000 after that edge and puts the controller in `ST_IDLE`.
- R2: `serve_sel` is always one-hot or all zero. Bit 0 selects bin 1, bit 1 selects bin 2, bit 2 selects bin 3.
- R3: `bin_low` is sampled at a rising edge. The decision based on it appears on `serve_sel` right after that edge and holds for the whole period. `bin_low` uses the same bit order as `serve_sel`, and 1 means the bin needs service.
- R4: When `bin_low` is 3'b000, `serve_sel` becomes 3'b000 and the controller returns to `ST_IDLE`, which discards the history.
- R5: When exactly one bin requests, that bin is selected in every period for as long as it alone requests.
- R6: When exactly two bins request, they are selected alternately, period by period.
- R7: When all three bins request, the selection rotates bin 1, bin 2, bin 3, bin 1, and so on.
- R8: From `ST_IDLE`, the lowest-numbered requesting bin is selected first, so bin 1 wins over bin 3.
- R9: If the bin next in rotation after the last served one is not requesting, it is skipped. The next requesting bin in rotation order is served instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bin_low | input | 3 | Level sensors, 1 = bin needs service (bit 0 = bin 1) |
| serve_sel | output | 3 | Registered one-hot bin selection, zero when idle |

## Verification
Every result of this block is due exactly one rising edge after the `bin_low` or `rst` value it depends on. The same edge updates both the state register and the registered `serve_sel`.

The bench drives inputs on the falling edge and queues the expected selection at that moment. The monitor compares it 1 ns after the next rising edge, so each comparison lands in the one cycle where the answer first becomes visible.

The expected values come from a bench-side model of the last-served bin and the cyclic search, written from the requirements alone.

// File: rtl/trolley_pkg.sv
package trolley_pkg;
    localparam int N_BINS = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAST1 = 2'd1,
        ST_LAST2 = 2'd2,
        ST_LAST3 = 2'd3
    } sched_state_t;
endpackage

// File: rtl/trolley_state_dec.sv
// Turns the history state into a one-hot "served last" vector for the picker.
module trolley_state_dec
    import trolley_pkg::*;
(
    input  sched_state_t      state,
    output logic [N_BINS-1:0] last_oh
);
    always_comb begin
        unique case (state)
            ST_LAST1: last_oh = 3'b001;
            ST_LAST2: last_oh = 3'b010;
            ST_LAST3: last_oh = 3'b100;
            default:  last_oh = 3'b000;
        endcase
    end
endmodule

// File: rtl/trolley_rr_pick.sv
// Cyclic search: first requester strictly after the last served position.
// An empty last_oh counts as "last position served", so the search starts at bit 0.
module trolley_rr_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] last_oh,
    output logic [N-1:0] grant
);
    int   last_idx;
    int   idx;
    logic found;

    always_comb begin
        last_idx = N - 1;
        for (int i = 0; i < N; i++) begin
            if (last_oh[i]) last_idx = i;
        end
        grant = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (last_idx + k) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trolley_sched.sv
module trolley_sched
    import trolley_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BINS-1:0] bin_low,
    output logic [N_BINS-1:0] serve_sel
);
    sched_state_t      state_q;
    sched_state_t      state_d;
    logic [N_BINS-1:0] last_oh;
    logic [N_BINS-1:0] grant;

    trolley_state_dec dec_i (
        .state   (state_q),
        .last_oh (last_oh)
    );

    trolley_rr_pick #(.N(N_BINS)) pick_i (
        .req     (bin_low),
        .last_oh (last_oh),
        .grant   (grant)
    );

    // Transition: a grant names the new last-served bin; no grant returns to idle.
    always_comb begin
        unique case (grant)
            3'b001:  state_d = ST_LAST1;
            3'b010:  state_d = ST_LAST2;
            3'b100:  state_d = ST_LAST3;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) serve_sel <= '0;
        else     serve_sel <= grant;
    end
endmodule

// File: rtl/trolley_sched_chk.sv
module trolley_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] bin_low,
    input logic [2:0] serve_sel
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> serve_sel == 3'b000); // R1
    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(serve_sel)); // R2
    AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (rst)
        (bin_low != 3'b000) |=> ((serve_sel & $past(bin_low)) != 3'b000)); // R3
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bin_low == 3'b000) |=> serve_sel == 3'b000); // R4
    AST_SINGLE_SERVED: assert property (@(posedge clk) disable iff (rst)
        $onehot(bin_low) |=> serve_sel == $past(bin_low)); // R5
    AST_PAIR_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        ($countones(bin_low) == 2 && (serve_sel & bin_low) != 3'b000)
        |=> serve_sel == ($past(bin_low) & ~$past(serve_sel))); // R6
    AST_ALL_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (bin_low == 3'b111 && serve_sel != 3'b000)
        |=> serve_sel == {$past(serve_sel[1:0]), $past(serve_sel[2])}); // R7
    AST_IDLE_BIN1_FIRST: assert property (@(posedge clk) disable iff (rst)
        (serve_sel == 3'b000 && bin_low[0]) |=> serve_sel == 3'b001); // R8
    AST_SKIP_FROM_BIN1: assert property (@(posedge clk) disable iff (rst)
        (serve_sel == 3'b001 && bin_low == 3'b101) |=> serve_sel == 3'b100); // R9
endmodule

bind trolley_sched trolley_sched_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bin_low   (bin_low),
    .serve_sel (serve_sel)
);

// File: tb/trolley_sched_tb_top.sv
module trolley_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bin_low = 3'b000;
    logic [2:0] serve_sel;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    int model_last = 0;   // 0 = idle, else bin number served last
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    trolley_sched dut_i (
        .clk       (clk),
        .rst       (rst),
        .bin_low   (bin_low),
        .serve_sel (serve_sel)
    );

    // Driver: apply stimulus on the falling edge and queue the expected selection.
    task automatic drive(input logic r, input logic [2:0] req, input string tag);
        sb_item_t   it;
        logic [2:0] e;
        @(negedge clk);
        rst     = r;
        bin_low = req;
        e       = 3'b000;
        if (r || req == 3'b000) begin
            model_last = 0;
        end else begin
            for (int k = 1; k <= 3; k++) begin
                int b;
                b = ((model_last + k - 1) % 3) + 1;
                if (e == 3'b000 && req[b-1]) e[b-1] = 1'b1;
            end
            for (int b = 1; b <= 3; b++) if (e[b-1]) model_last = b;
        end
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare 1 ns after the rising edge that produces the result.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (serve_sel !== it.exp) begin
                    errors++;
                    $display("FAIL %s: serve_sel=%b expected=%b", it.tag, serve_sel, it.exp);
                end
                checks++;
                if (!$onehot0(serve_sel)) begin
                    errors++;
                    $display("FAIL R2: serve_sel=%b expected one-hot or zero", serve_sel);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        drive(1'b1, 3'b111, "R1 reset");
        drive(1'b1, 3'b000, "R1 reset");
        drive(1'b0, 3'b000, "R4 no request");
        drive(1'b0, 3'b001, "R5 single bin1");
        drive(1'b0, 3'b001, "R5 single bin1 repeat");
        drive(1'b0, 3'b001, "R3 held decision");
        drive(1'b0, 3'b100, "R5 single bin3");
        drive(1'b0, 3'b100, "R5 single bin3 repeat");
        drive(1'b0, 3'b101, "R6 pair 1/3");
        drive(1'b0, 3'b101, "R6 pair 1/3");
        drive(1'b0, 3'b101, "R6 pair 1/3");
        drive(1'b0, 3'b110, "R6 pair 2/3");
        drive(1'b0, 3'b110, "R6 pair 2/3");
        drive(1'b0, 3'b110, "R6 pair 2/3");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b111, "R7 all three");
        drive(1'b0, 3'b000, "R4 history cleared");
        drive(1'b0, 3'b111, "R8 idle all, bin1 first");
        drive(1'b0, 3'b000, "R4 no request");
        drive(1'b0, 3'b110, "R8 idle, bin2 before bin3");
        drive(1'b0, 3'b000, "R4 no request");
        drive(1'b0, 3'b101, "R8 idle, bin1 over bin3");
        drive(1'b0, 3'b101, "R9 skip bin2 after bin1");
        drive(1'b0, 3'b010, "R5 single bin2");
        drive(1'b0, 3'b011, "R9 skip bin3 after bin2");
        drive(1'b0, 3'b111, "R7 rotate on from bin1");
        drive(1'b1, 3'b111, "R1 reset mid-run");
        drive(1'b0, 3'b100, "R8 idle, only bin3");
        drive(1'b0, 3'b000, "R4 no request");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule